// File: doc/BRIEF.md
# Daily Bell Schedule Matcher

This block keeps a list of daily ring times and drives a bell relay when the wall clock reaches one of them. Each ring time is an hour and a minute, both in BCD. The list holds up to `N_ENTRIES` times, 40 by default. An external real-time clock supplies the current BCD hour, minute and second, together with a strobe that pulses once per second. When the second reads 00 and the hour and minute equal a stored time, the relay output goes high for `RING_SECS` second strobes.

Software edits a working copy of the list with single-cycle commands: insert a time, remove the entry at an index, publish the edits, or throw them away. Every insertion goes straight into its ascending position. The working copy is therefore always in order, and the read port returns the i-th earliest time. Publishing copies the working list into the live list that the matcher uses. Discarding copies the live list back into the working list. While edits are pending, the matcher is paused, so a half-edited list can never ring the bell.

Top module: `bell_sched`

## Requirements
- R1: After reset both lists are empty, `entry_count` is 0 and `full`, `edit_open`, `relay_on` and `rd_valid` are 0.
- R2: `ed_add` inserts {`ed_hour`,`ed_min`} into the working list. The list is ordered by the 16-bit key {hour,minute}, smallest first, and an insert lands after any equal keys. Reading index i returns the i-th entry with `rd_valid`=1 when i < `entry_count`. Otherwise `rd_valid`=0 and the read port returns hour and minute 00.
- R3: `full` is 1 exactly when `entry_count` equals `N_ENTRIES`. An add while full is refused and leaves the working list unchanged.
- R4: `ed_del` with `ed_idx` < `entry_count` removes that entry and moves each later entry down one place. With `ed_idx` >= `entry_count` the list is left unchanged.
- R5: Any add or delete, including a refused one, sets `edit_open`. `ed_commit` copies the working list into the live list. `ed_cancel` copies the live list back into the working list. Both clear `edit_open`. When several commands arrive in one cycle, the order of precedence is cancel, then commit, then delete, then add.
- R6: A match is tested only on a `sec_tick` with `tm_sec` = 8'h00, and only against live entries. No match is taken while `edit_open` is 1.
- R7: `relay_on` rises in the cycle after a matching strobe and stays high until `RING_SECS` further strobes have been seen. It then falls in the cycle after the last of them. A match while ringing restarts the full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_tick | input | 1 | One-cycle pulse once per second |
| tm_hour | input | 8 | Current hour, BCD |
| tm_min | input | 8 | Current minute, BCD |
| tm_sec | input | 8 | Current second, BCD |
| ed_add | input | 1 | Insert {ed_hour,ed_min} |
| ed_del | input | 1 | Remove entry at ed_idx |
| ed_commit | input | 1 | Publish working list |
| ed_cancel | input | 1 | Restore working list from live list |
| ed_idx | input | CW | Index for delete |
| ed_hour | input | 8 | Hour to insert, BCD |
| ed_min | input | 8 | Minute to insert, BCD |
| rd_idx | input | CW | Browse index into working list |
| rd_hour | output | 8 | Hour at rd_idx |
| rd_min | output | 8 | Minute at rd_idx |
| rd_valid | output | 1 | rd_idx addresses a valid entry |
| entry_count | output | CW | Valid entries in working list |
| full | output | 1 | Working list at capacity |
| edit_open | output | 1 | Uncommitted edits pending |
| relay_on | output | 1 | Bell relay drive |

CW = $clog2(N_ENTRIES+1).

## Verification
The bench builds the block with `N_ENTRIES`=4 and `RING_SECS`=3. Four inserts then fill the list, so the refused fifth insert and the `full` flag can be checked within a few cycles. A short ring also lets the bench count every strobe up to release, and check a restart while ringing, without long waits. Index values at and beyond the count check that deletes are ignored, and one-cycle command collisions check the precedence.

// File: rtl/bell_pkg.sv
package bell_pkg;

   typedef struct packed {
      logic [7:0] hour;
      logic [7:0] min;
   } bell_entry_t;

   // BCD digits are monotonic, so plain unsigned compare of the packed key orders times.
   function automatic logic key_le(input bell_entry_t a, input bell_entry_t b);
      return {a.hour, a.min} <= {b.hour, b.min};
   endfunction

endpackage

// File: rtl/bell_table.sv
module bell_table
   import bell_pkg::*;
#(
   parameter int N  = 40,
   parameter int CW = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ed_add,
   input  logic                  ed_del,
   input  logic                  ed_commit,
   input  logic                  ed_cancel,
   input  logic [CW-1:0]         ed_idx,
   input  bell_entry_t           ed_entry,
   input  logic [CW-1:0]         rd_idx,
   output bell_entry_t           rd_entry,
   output logic                  rd_valid,
   output logic [CW-1:0]         wk_count,
   output logic                  full,
   output logic                  edit_open,
   output bell_entry_t [N-1:0]   live_tab,
   output logic [CW-1:0]         live_count
);

   bell_entry_t [N-1:0] wk_q, live_q, ins_tab, del_tab;
   logic [CW-1:0]       wk_cnt_q, live_cnt_q, ins_pos;
   logic                edit_q;
   logic                del_ok;

   assign full   = (wk_cnt_q == CW'(N));
   assign del_ok = (ed_idx < wk_cnt_q);

   // Insertion point: number of valid entries not later than the new key (R2)
   always_comb begin
      ins_pos = '0;
      for (int i = 0; i < N; i++) begin
         if (CW'(i) < wk_cnt_q && key_le(wk_q[i], ed_entry))
            ins_pos = ins_pos + CW'(1);
      end
   end

   // Per-slot shift networks for insert and delete
   for (genvar i = 0; i < N; i++) begin : g_slot
      if (i == 0) begin : g_ins_first
         assign ins_tab[i] = (ins_pos == '0) ? ed_entry : wk_q[i];
      end else begin : g_ins_rest
         assign ins_tab[i] = (CW'(i) < ins_pos)  ? wk_q[i]  :
                             (CW'(i) == ins_pos) ? ed_entry : wk_q[i-1];
      end
      if (i == N-1) begin : g_del_last
         assign del_tab[i] = (CW'(i) < ed_idx) ? wk_q[i] : '0;
      end else begin : g_del_rest
         assign del_tab[i] = (CW'(i) < ed_idx) ? wk_q[i] : wk_q[i+1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wk_q       <= '0;
         live_q     <= '0;
         wk_cnt_q   <= '0;
         live_cnt_q <= '0;
         edit_q     <= 1'b0;
      end else if (ed_cancel) begin
         wk_q     <= live_q;
         wk_cnt_q <= live_cnt_q;
         edit_q   <= 1'b0;
      end else if (ed_commit) begin
         live_q     <= wk_q;
         live_cnt_q <= wk_cnt_q;
         edit_q     <= 1'b0;
      end else if (ed_del) begin
         if (del_ok) begin
            wk_q     <= del_tab;
            wk_cnt_q <= wk_cnt_q - CW'(1);
         end
         edit_q <= 1'b1;
      end else if (ed_add) begin
         if (!full) begin
            wk_q     <= ins_tab;
            wk_cnt_q <= wk_cnt_q + CW'(1);
         end
         edit_q <= 1'b1;
      end
   end

   // Browse port on the working list
   always_comb begin
      rd_entry = '0;
      rd_valid = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (CW'(i) == rd_idx && CW'(i) < wk_cnt_q) begin
            rd_entry = wk_q[i];
            rd_valid = 1'b1;
         end
      end
   end

   assign wk_count   = wk_cnt_q;
   assign edit_open  = edit_q;
   assign live_tab   = live_q;
   assign live_count = live_cnt_q;

endmodule

// File: rtl/bell_match.sv
module bell_match
   import bell_pkg::*;
#(
   parameter int N  = 40,
   parameter int CW = 6
) (
   input  bell_entry_t [N-1:0] tab,
   input  logic [CW-1:0]       count,
   input  bell_entry_t         now,
   output logic                hit
);

   logic [N-1:0] eq;

   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign eq[i] = (CW'(i) < count) && (tab[i] == now);
   end

   assign hit = |eq;

endmodule

// File: rtl/bell_ringer.sv
module bell_ringer #(
   parameter int RING_SECS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sec_tick,
   input  logic start,
   output logic relay_on
);

   localparam int RW = $clog2(RING_SECS + 1);

   if (RING_SECS == 1) begin : g_single
      logic on_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        on_q <= 1'b0;
         else if (start)    on_q <= 1'b1;
         else if (sec_tick) on_q <= 1'b0;
      end
      assign relay_on = on_q;
   end else begin : g_count
      logic [RW-1:0] left_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            left_q <= '0;
         else if (start)
            left_q <= RW'(RING_SECS);
         else if (sec_tick && left_q != '0)
            left_q <= left_q - RW'(1);
      end
      assign relay_on = (left_q != '0);
   end

endmodule

// File: rtl/bell_sched.sv
module bell_sched
   import bell_pkg::*;
#(
   parameter  int N_ENTRIES = 40,
   parameter  int RING_SECS = 10,
   localparam int CW        = $clog2(N_ENTRIES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sec_tick,
   input  logic [7:0]    tm_hour,
   input  logic [7:0]    tm_min,
   input  logic [7:0]    tm_sec,
   input  logic          ed_add,
   input  logic          ed_del,
   input  logic          ed_commit,
   input  logic          ed_cancel,
   input  logic [CW-1:0] ed_idx,
   input  logic [7:0]    ed_hour,
   input  logic [7:0]    ed_min,
   input  logic [CW-1:0] rd_idx,
   output logic [7:0]    rd_hour,
   output logic [7:0]    rd_min,
   output logic          rd_valid,
   output logic [CW-1:0] entry_count,
   output logic          full,
   output logic          edit_open,
   output logic          relay_on
);

   if (N_ENTRIES < 1 || N_ENTRIES > 255) begin : g_bad_entries
      $error("bell_sched: N_ENTRIES must lie in 1..255");
   end
   if (RING_SECS < 1) begin : g_bad_ring
      $error("bell_sched: RING_SECS must be at least 1");
   end

   bell_entry_t             ed_entry, now_entry, rd_entry;
   bell_entry_t [N_ENTRIES-1:0] live_tab;
   logic [CW-1:0]           live_count;
   logic                    hit, minute_edge, ring_start;

   assign ed_entry.hour  = ed_hour;
   assign ed_entry.min   = ed_min;
   assign now_entry.hour = tm_hour;
   assign now_entry.min  = tm_min;

   bell_table #(.N(N_ENTRIES), .CW(CW)) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .ed_add     (ed_add),
      .ed_del     (ed_del),
      .ed_commit  (ed_commit),
      .ed_cancel  (ed_cancel),
      .ed_idx     (ed_idx),
      .ed_entry   (ed_entry),
      .rd_idx     (rd_idx),
      .rd_entry   (rd_entry),
      .rd_valid   (rd_valid),
      .wk_count   (entry_count),
      .full       (full),
      .edit_open  (edit_open),
      .live_tab   (live_tab),
      .live_count (live_count)
   );

   bell_match #(.N(N_ENTRIES), .CW(CW)) u_match (
      .tab   (live_tab),
      .count (live_count),
      .now   (now_entry),
      .hit   (hit)
   );

   // Only the strobe at second 00 may fire, and never with edits pending (R6)
   assign minute_edge = sec_tick && (tm_sec == 8'h00) && !edit_open;
   assign ring_start  = minute_edge && hit;

   bell_ringer #(.RING_SECS(RING_SECS)) u_ringer (
      .clk      (clk),
      .rst_n    (rst_n),
      .sec_tick (sec_tick),
      .start    (ring_start),
      .relay_on (relay_on)
   );

   assign rd_hour = rd_entry.hour;
   assign rd_min  = rd_entry.min;

endmodule

// File: rtl/bell_sched_chk.sv
module bell_sched_chk #(
   parameter  int N_ENTRIES = 40,
   localparam int CW        = $clog2(N_ENTRIES + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sec_tick,
   input logic [7:0]    tm_sec,
   input logic          ed_add,
   input logic          ed_del,
   input logic          ed_commit,
   input logic          ed_cancel,
   input logic [CW-1:0] ed_idx,
   input logic [CW-1:0] entry_count,
   input logic          full,
   input logic          edit_open,
   input logic          relay_on
);

   a_r3_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
      (ed_add && !ed_del && !ed_commit && !ed_cancel && full) |=> $stable(entry_count));

   a_r4_del_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
      (ed_del && !ed_commit && !ed_cancel && ed_idx < entry_count)
         |=> entry_count == $past(entry_count) - CW'(1));

   a_r5_edit_opens: assert property (@(posedge clk) disable iff (!rst_n)
      ((ed_add || ed_del) && !ed_commit && !ed_cancel) |=> edit_open);

   a_r5_publish_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (ed_commit || ed_cancel) |=> !edit_open);

   a_r6_ring_on_minute: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(relay_on) |-> $past(sec_tick && tm_sec == 8'h00 && !edit_open));

   a_r7_relay_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (relay_on && !sec_tick) |=> relay_on);

endmodule

bind bell_sched bell_sched_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sec_tick    (sec_tick),
   .tm_sec      (tm_sec),
   .ed_add      (ed_add),
   .ed_del      (ed_del),
   .ed_commit   (ed_commit),
   .ed_cancel   (ed_cancel),
   .ed_idx      (ed_idx),
   .entry_count (entry_count),
   .full        (full),
   .edit_open   (edit_open),
   .relay_on    (relay_on)
);

// File: tb/bell_sched_tb.sv
module bell_sched_tb;

   localparam int N  = 4;
   localparam int RS = 3;
   localparam int CW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sec_tick = 1'b0;
   logic [7:0]    tm_hour = '0, tm_min = '0, tm_sec = '0;
   logic          ed_add = 1'b0, ed_del = 1'b0, ed_commit = 1'b0, ed_cancel = 1'b0;
   logic [CW-1:0] ed_idx = '0, rd_idx = '0;
   logic [7:0]    ed_hour = '0, ed_min = '0;
   logic [7:0]    rd_hour, rd_min;
   logic          rd_valid, full, edit_open, relay_on;
   logic [CW-1:0] entry_count;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   bell_sched #(.N_ENTRIES(N), .RING_SECS(RS)) u_dut (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
      .tm_hour(tm_hour), .tm_min(tm_min), .tm_sec(tm_sec),
      .ed_add(ed_add), .ed_del(ed_del), .ed_commit(ed_commit), .ed_cancel(ed_cancel),
      .ed_idx(ed_idx), .ed_hour(ed_hour), .ed_min(ed_min), .rd_idx(rd_idx),
      .rd_hour(rd_hour), .rd_min(rd_min), .rd_valid(rd_valid),
      .entry_count(entry_count), .full(full), .edit_open(edit_open), .relay_on(relay_on)
   );

   // {hour, minute, expected count, expected full}
   localparam logic [23:0] ADD_VEC [5] = '{
      {8'h07, 8'h30, 4'd1, 4'd0},
      {8'h06, 8'h15, 4'd2, 4'd0},
      {8'h12, 8'h00, 4'd3, 4'd0},
      {8'h06, 8'h45, 4'd4, 4'd1},
      {8'h09, 8'h00, 4'd4, 4'd1}
   };
   localparam logic [15:0] SORTED [4] = '{16'h0615, 16'h0645, 16'h0730, 16'h1200};

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_add(input logic [7:0] h, input logic [7:0] m);
      ed_hour = h; ed_min = m; ed_add = 1'b1;
      @(negedge clk);
      ed_add = 1'b0;
   endtask

   task automatic do_del(input logic [CW-1:0] idx);
      ed_idx = idx; ed_del = 1'b1;
      @(negedge clk);
      ed_del = 1'b0;
   endtask

   task automatic do_commit();
      ed_commit = 1'b1;
      @(negedge clk);
      ed_commit = 1'b0;
   endtask

   task automatic do_cancel();
      ed_cancel = 1'b1;
      @(negedge clk);
      ed_cancel = 1'b0;
   endtask

   task automatic do_tick(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
      tm_hour = h; tm_min = m; tm_sec = s; sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [CW-1:0] idx,
                         input logic [15:0] exp_key, input logic exp_v);
      rd_idx = idx;
      #1;
      chk(req, "read key", {rd_hour, rd_min}, exp_key);
      chk(req, "read valid", rd_valid, exp_v);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1", "count", entry_count, 0);
      chk("R1", "full", full, 0);
      chk("R1", "edit_open", edit_open, 0);
      chk("R1", "relay", relay_on, 0);
      rd_chk("R1", 0, 16'h0000, 1'b0);

      // R2/R3 insert vectors
      for (int k = 0; k < 5; k++) begin
         do_add(ADD_VEC[k][23:16], ADD_VEC[k][15:8]);
         chk("R2", "count after add", entry_count, ADD_VEC[k][7:4]);
         chk("R3", "full after add", full, ADD_VEC[k][3:0]);
      end
      for (int k = 0; k < 4; k++) rd_chk("R2", CW'(k), SORTED[k], 1'b1);
      rd_chk("R2", 4, 16'h0000, 1'b0);
      chk("R5", "edit open after adds", edit_open, 1);

      do_commit();
      chk("R5", "commit closes", edit_open, 0);
      chk("R5", "count kept", entry_count, 4);

      // R6 second must be 00, minute must match
      do_tick(8'h06, 8'h15, 8'h05);
      chk("R6", "nonzero second", relay_on, 0);
      do_tick(8'h06, 8'h14, 8'h00);
      chk("R6", "other minute", relay_on, 0);
      do_tick(8'h06, 8'h15, 8'h00);
      chk("R7", "relay rises", relay_on, 1);
      repeat (4) @(negedge clk);
      chk("R7", "relay holds idle", relay_on, 1);
      do_tick(8'h06, 8'h16, 8'h00);
      chk("R7", "after strobe 1", relay_on, 1);
      do_tick(8'h06, 8'h16, 8'h01);
      chk("R7", "after strobe 2", relay_on, 1);
      do_tick(8'h06, 8'h16, 8'h02);
      chk("R7", "release after strobe 3", relay_on, 0);

      // R4 delete with shift, out-of-range ignored
      do_del(1);
      chk("R4", "count after delete", entry_count, 3);
      chk("R3", "full drops", full, 0);
      rd_chk("R4", 0, 16'h0615, 1'b1);
      rd_chk("R4", 1, 16'h0730, 1'b1);
      rd_chk("R4", 2, 16'h1200, 1'b1);
      rd_chk("R4", 3, 16'h0000, 1'b0);
      do_del(3);
      chk("R4", "idx==count ignored", entry_count, 3);
      do_del(6);
      chk("R4", "idx>count ignored", entry_count, 3);
      rd_chk("R4", 2, 16'h1200, 1'b1);

      // R6 suspended while editing
      do_tick(8'h07, 8'h30, 8'h00);
      chk("R6", "no ring while editing", relay_on, 0);

      // R5 cancel restores
      do_cancel();
      chk("R5", "cancel closes", edit_open, 0);
      chk("R5", "cancel count", entry_count, 4);
      rd_chk("R5", 1, 16'h0645, 1'b1);

      // R3 refused add leaves table intact
      do_add(8'h05, 8'h00);
      chk("R3", "refused count", entry_count, 4);
      rd_chk("R3", 0, 16'h0615, 1'b1);
      chk("R5", "refused add opens edit", edit_open, 1);
      do_cancel();

      do_del(0);
      do_commit();
      chk("R5", "commit count", entry_count, 3);

      // R6 deleted live entry no longer rings
      do_tick(8'h06, 8'h15, 8'h00);
      chk("R6", "deleted time silent", relay_on, 0);
      do_tick(8'h06, 8'h45, 8'h00);
      chk("R7", "ring second run", relay_on, 1);
      do_tick(8'h06, 8'h46, 8'h00);
      do_tick(8'h07, 8'h30, 8'h00);
      chk("R7", "retrigger on", relay_on, 1);
      do_tick(8'h07, 8'h31, 8'h00);
      do_tick(8'h07, 8'h31, 8'h01);
      chk("R7", "retrigger reloaded", relay_on, 1);
      do_tick(8'h07, 8'h31, 8'h02);
      chk("R7", "retrigger release", relay_on, 0);

      // R5 precedence: cancel over delete, commit over add
      ed_idx = 0; ed_del = 1'b1; ed_cancel = 1'b1;
      @(negedge clk);
      ed_del = 1'b0; ed_cancel = 1'b0;
      chk("R5", "cancel beats delete count", entry_count, 3);
      chk("R5", "cancel beats delete edit", edit_open, 0);
      rd_chk("R5", 0, 16'h0645, 1'b1);
      ed_hour = 8'h05; ed_min = 8'h00; ed_add = 1'b1; ed_commit = 1'b1;
      @(negedge clk);
      ed_add = 1'b0; ed_commit = 1'b0;
      chk("R5", "commit beats add count", entry_count, 3);
      chk("R5", "commit beats add edit", edit_open, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule